// File: doc/BRIEF.md
# Decade-Stepped Sample Strobe Generator

This block derives a sample-enable strobe from a free-running master sample clock. Software picks an output rate as a mantissa from the set 1, 2, 2.5, 4, 5 times a power of ten. The block turns that choice into a division of the master rate. The division runs through a chain of divide-by-ten stages followed by a small mantissa counter. For the one ratio that is not a whole number, the mantissa counter alternates intervals of two and three.

A rate setting is written with a single-cycle write pulse. An illegal setting raises an error flag and is discarded. A legal setting waits in a pending register and is loaded only when the running divider reaches its terminal count, so the strobe train never shows a shortened or merged interval. A select input can switch the output to an external clock-enable input, which then qualifies samples in place of the internal divider.

Top module: `srate_strobe_gen`

## Requirements
- R1: With mantissa code c (0=1, 1=2, 2=2.5, 3=4, 4=5) and exponent e, the strobe rate is mantissa(c)·10^e in units where the master rate is 10^TOP_EXP. The distance in master cycles between consecutive strobes is therefore 10^TOP_EXP / (mantissa(c)·10^e).
- R2: When that distance is 2.5 (code 3, e = TOP_EXP-1), consecutive intervals alternate 2, 3, 2, 3, and the first interval after the setting is applied is 2.
- R3: A setting is legal only when c ≤ 4, MIN_EXP ≤ e ≤ TOP_EXP, and, at e = TOP_EXP, only c = 0. Codes 5 to 7 are illegal at every exponent.
- R4: A write of an illegal setting sets `cfg_err` in the next cycle and leaves the running rate unchanged.
- R5: A write of a legal setting clears `cfg_err` in the next cycle.
- R6: A legal setting takes effect at the next terminal count of the running divider. The interval ending at that strobe still has the old length, and the following interval has the new length.
- R7: Each strobe is high for one master cycle. Two consecutive strobe cycles occur only when the distance is 1.
- R8: While `ext_sel` is 1, `sample_en` equals `ext_en` in the same cycle, and the internal divider has no effect on the output.
- R9: After reset, `cfg_err` is 0 and the rate is the full master rate, with a strobe in every cycle.
- R10: Equal mantissa codes at consecutive exponents give intervals that differ by a factor of ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle write pulse for a new rate setting |
| cfg_mant | input | 3 | Mantissa code (0=1, 1=2, 2=2.5, 3=4, 4=5) |
| cfg_exp | input | EXP_W | Decade exponent of the requested rate |
| ext_sel | input | 1 | 1 selects the external clock-enable as sample qualifier |
| ext_en | input | 1 | External clock-enable |
| sample_en | output | 1 | Sample strobe |
| cfg_err | output | 1 | Last write held an illegal setting |

## Verification
The rate table is walked through every mantissa code at several exponents. Equal intervals separate the integer mantissas, and an alternating pair exposes the 2/3 schedule of the 2.5 ratio and its starting phase. The table mixes long-to-short and short-to-long changes, so the interval that ends at the terminal count is checked against both the old length and the new one. Illegal writes cover each boundary (a bad code, one decade too low, one decade too high, and a non-unit mantissa at the top decade), and the running interval is then measured to show that nothing moved. A bit pattern on the external enable, with the select asserted, is compared cycle by cycle against the output while the internal divider keeps running.

// File: rtl/srate_pkg.sv
package srate_pkg;
   localparam int DEC_W = 4;   // width of the decade-stage count
   localparam int LEN_W = 5;   // width of the mantissa counter

   typedef enum logic [2:0] {
      MANT_1   = 3'd0,
      MANT_2   = 3'd1,
      MANT_2P5 = 3'd2,
      MANT_4   = 3'd3,
      MANT_5   = 3'd4
   } mant_code_e;

   // Divider configuration: number of active decade stages, last value of
   // the mantissa counter, and the alternating two/three mode.
   typedef struct packed {
      logic [DEC_W-1:0] dec;
      logic [LEN_W-1:0] last;
      logic             frac;
   } div_cfg_t;
endpackage

// File: rtl/srate_decode.sv
module srate_decode
   import srate_pkg::*;
#(
   parameter int TOP_EXP = 9,
   parameter int MIN_EXP = 2,
   parameter int EXP_W   = 4
) (
   input  logic [2:0]       mant_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             ok_o,
   output div_cfg_t         cfg_o
);
   // The divide ratio is 10^TOP_EXP / (m * 10^e). It is split into a
   // power-of-ten count (decade stages) and a small mantissa length.
   always_comb begin
      int e;
      int kk;
      e     = int'(exp_i);
      ok_o  = (mant_i <= 3'd4) && (e >= MIN_EXP) && (e <= TOP_EXP)
              && ((e < TOP_EXP) || (mant_i == 3'd0));
      kk    = 0;
      cfg_o = '0;
      if (ok_o) begin
         kk = (mant_i == 3'd0) ? (TOP_EXP - e) : (TOP_EXP - 1 - e);
         case (mant_code_e'(mant_i))
            MANT_1:   cfg_o.last = LEN_W'(0);    // ratio 1 x 10^kk
            MANT_2:   cfg_o.last = LEN_W'(4);    // ratio 5 x 10^kk
            MANT_2P5: cfg_o.last = LEN_W'(3);    // ratio 4 x 10^kk
            MANT_4: begin                        // ratio 2.5 x 10^kk
               if (kk == 0) begin
                  cfg_o.frac = 1'b1;
                  cfg_o.last = LEN_W'(1);
               end else begin
                  cfg_o.last = LEN_W'(24);       // 25 x 10^(kk-1)
                  kk         = kk - 1;
               end
            end
            MANT_5:   cfg_o.last = LEN_W'(1);    // ratio 2 x 10^kk
            default:  cfg_o.last = LEN_W'(0);
         endcase
         cfg_o.dec = DEC_W'(kk);
      end
   end
endmodule

// File: rtl/srate_decade_chain.sv
module srate_decade_chain
   import srate_pkg::*;
#(
   parameter int N_STG = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [DEC_W-1:0] dec_i,
   output logic             tick_o
);
   // carry[i] pulses once every 10^i cycles
   logic [N_STG:0] carry;
   assign carry[0] = 1'b1;

   for (genvar g = 0; g < N_STG; g++) begin : g_stg
      logic [3:0] dig;
      logic       run;
      assign run = (DEC_W'(g) < dec_i);

      always_ff @(posedge clk) begin
         if (!rst_n)               dig <= 4'd0;
         else if (clr_i || !run)   dig <= 4'd0;
         else if (carry[g])        dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
      end

      assign carry[g+1] = carry[g] && (dig == 4'd9);

      AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         dig <= 4'd9);                                      // R1
   end

   always_comb begin
      tick_o = carry[0];
      for (int i = 1; i <= N_STG; i++) begin
         if (dec_i == DEC_W'(i)) tick_o = carry[i];
      end
   end
endmodule

// File: rtl/srate_mant_div.sv
module srate_mant_div
   import srate_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic [LEN_W-1:0] last_i,
   input  logic             frac_i,
   output logic             wrap_o
);
   logic [LEN_W-1:0] cnt_q;
   logic             phase_q;
   logic [LEN_W-1:0] end_val;
   logic             at_end;

   // Alternating mode ends at 1 (two ticks) then at 2 (three ticks).
   assign end_val = frac_i ? (phase_q ? LEN_W'(2) : LEN_W'(1)) : last_i;
   assign at_end  = (cnt_q == end_val);
   assign wrap_o  = adv_i && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (adv_i) begin
         if (at_end) begin
            cnt_q   <= '0;
            phase_q <= frac_i ? ~phase_q : 1'b0;
         end else begin
            cnt_q   <= cnt_q + LEN_W'(1);
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= end_val);                                    // R1
   AST_FRAC_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      !frac_i |-> !phase_q);                                // R2
endmodule

// File: rtl/srate_strobe_gen.sv
module srate_strobe_gen
   import srate_pkg::*;
#(
   parameter int TOP_EXP = 9,
   parameter int MIN_EXP = 2,
   parameter int EXP_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [2:0]       cfg_mant,
   input  logic [EXP_W-1:0] cfg_exp,
   input  logic             ext_sel,
   input  logic             ext_en,
   output logic             sample_en,
   output logic             cfg_err
);
   localparam int N_STG = TOP_EXP - MIN_EXP;

   if (N_STG < 1 || N_STG > 15)
      $error("srate_strobe_gen: TOP_EXP - MIN_EXP must lie in 1..15");
   if (MIN_EXP < 0)
      $error("srate_strobe_gen: MIN_EXP must not be negative");
   if ((1 << EXP_W) <= TOP_EXP)
      $error("srate_strobe_gen: EXP_W too narrow for TOP_EXP");

   localparam div_cfg_t FULL_RATE = '{dec: '0, last: '0, frac: 1'b0};

   div_cfg_t act_q, pend_q, wr_cfg;
   logic     pend_v_q, wr_ok, err_q;
   logic     tick, term, reload, unit_ratio;

   srate_decode #(.TOP_EXP(TOP_EXP), .MIN_EXP(MIN_EXP), .EXP_W(EXP_W)) u_dec (
      .mant_i (cfg_mant),
      .exp_i  (cfg_exp),
      .ok_o   (wr_ok),
      .cfg_o  (wr_cfg)
   );

   srate_decade_chain #(.N_STG(N_STG)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (reload),
      .dec_i  (act_q.dec),
      .tick_o (tick)
   );

   srate_mant_div u_mant (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (reload),
      .adv_i  (tick),
      .last_i (act_q.last),
      .frac_i (act_q.frac),
      .wrap_o (term)
   );

   assign reload     = term && pend_v_q;
   assign unit_ratio = (act_q.dec == '0) && (act_q.last == '0) && !act_q.frac;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q    <= FULL_RATE;
         pend_q   <= FULL_RATE;
         pend_v_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         if (reload) begin
            act_q    <= pend_q;
            pend_v_q <= 1'b0;
         end
         if (cfg_wr) begin
            if (wr_ok) begin
               pend_q   <= wr_cfg;
               pend_v_q <= 1'b1;
               err_q    <= 1'b0;
            end else begin
               err_q    <= 1'b1;
            end
         end
      end
   end

   assign sample_en = ext_sel ? ext_en : term;
   assign cfg_err   = err_q;

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      term && !unit_ratio && !reload |=> !term);            // R7
   AST_LOAD_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(act_q));                          // R6
   AST_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && !wr_ok |=> cfg_err && $stable(pend_q));     // R4
   AST_GOOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && wr_ok |=> !cfg_err && pend_v_q);            // R5
endmodule

// File: tb/srate_strobe_gen_tb.sv
module srate_strobe_gen_tb;
   localparam int TOP_EXP = 5;
   localparam int MIN_EXP = 2;
   localparam int EXP_W   = 4;
   localparam int NVEC    = 14;

   // {mantissa code, exponent, even-position interval, odd-position interval}
   localparam logic [30:0] VEC [NVEC] = '{
      {3'd0, 4'd4, 12'd10,   12'd10},
      {3'd3, 4'd4, 12'd2,    12'd3},
      {3'd1, 4'd4, 12'd5,    12'd5},
      {3'd2, 4'd3, 12'd40,   12'd40},
      {3'd3, 4'd3, 12'd25,   12'd25},
      {3'd4, 4'd4, 12'd2,    12'd2},
      {3'd0, 4'd3, 12'd100,  12'd100},
      {3'd3, 4'd2, 12'd250,  12'd250},
      {3'd1, 4'd3, 12'd50,   12'd50},
      {3'd2, 4'd4, 12'd4,    12'd4},
      {3'd4, 4'd2, 12'd200,  12'd200},
      {3'd0, 4'd5, 12'd1,    12'd1},
      {3'd0, 4'd2, 12'd1000, 12'd1000},
      {3'd0, 4'd4, 12'd10,   12'd10}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [2:0]       cfg_mant = '0;
   logic [EXP_W-1:0] cfg_exp = '0;
   logic             ext_sel = 1'b0;
   logic             ext_en = 1'b0;
   logic             sample_en;
   logic             cfg_err;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   srate_strobe_gen #(.TOP_EXP(TOP_EXP), .MIN_EXP(MIN_EXP), .EXP_W(EXP_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_mant  (cfg_mant),
      .cfg_exp   (cfg_exp),
      .ext_sel   (ext_sel),
      .ext_en    (ext_en),
      .sample_en (sample_en),
      .cfg_err   (cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2:0] m, input int e);
      @(negedge clk);
      cfg_mant = m;
      cfg_exp  = EXP_W'(e);
      cfg_wr   = 1'b1;
      @(posedge clk);
      #1 cfg_wr = 1'b0;
   endtask

   // Counts negedges up to and including the next one that shows a strobe.
   task automatic wait_strobe(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_en && n < 4000);
      if (!sample_en) check(1'b0, "strobe timeout", n, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int w;
      int prev_max;
      int ea, eb;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(cfg_err == 1'b0, "R9 err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(cfg_err == 1'b0, "R9 err after reset", int'(cfg_err), 0);
      check(sample_en == 1'b1, "R9 full rate strobe", int'(sample_en), 1);
      for (int j = 0; j < 3; j++) begin
         wait_strobe(w);
         check(w == 1, "R9 full rate interval", w, 1);
      end

      // Rate table walk
      prev_max = 1;
      for (int v = 0; v < NVEC; v++) begin
         ea = int'(VEC[v][23:12]);
         eb = int'(VEC[v][11:0]);
         write_cfg(VEC[v][30:28], int'(VEC[v][27:24]));
         check(cfg_err == 1'b0, "R5 legal write clears err", int'(cfg_err), 0);
         wait_strobe(w);
         check(w <= prev_max, "R6 old interval until terminal", w, prev_max);
         for (int j = 0; j < 4; j++) begin
            wait_strobe(w);
            if (ea != eb)
               check(w == ((j % 2 == 0) ? ea : eb), "R2 alternating interval",
                     w, (j % 2 == 0) ? ea : eb);
            else
               check(w == ea, "R1 R10 interval", w, ea);
         end
         prev_max = (ea > eb) ? ea : eb;
      end

      // Illegal settings: the rate stays at 10 cycles per strobe
      begin
         logic [2:0] bm [5] = '{3'd5, 3'd0, 3'd0, 3'd1, 3'd7};
         int         be [5] = '{4, 1, 6, 5, 3};
         for (int b = 0; b < 5; b++) begin
            write_cfg(bm[b], be[b]);
            @(negedge clk);
            check(cfg_err == 1'b1, "R3 R4 illegal write flagged", int'(cfg_err), 1);
            wait_strobe(w);
            wait_strobe(w);
            check(w == 10, "R4 rate held after illegal write", w, 10);
         end
      end

      write_cfg(3'd4, 4);
      @(negedge clk);
      check(cfg_err == 1'b0, "R5 err cleared", int'(cfg_err), 0);
      wait_strobe(w);
      wait_strobe(w);
      check(w == 2, "R1 rate after recovery", w, 2);

      // Width of a strobe at ratio 10
      write_cfg(3'd0, 4);
      wait_strobe(w);
      wait_strobe(w);
      @(negedge clk);
      check(sample_en == 1'b0, "R7 strobe one cycle wide", int'(sample_en), 0);

      // External enable path
      @(posedge clk);
      #1 ext_sel = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk);
         #1 ext_en = 1'b0;
         @(negedge clk);
         check(sample_en == 1'b0, "R8 internal strobe masked", int'(sample_en), 0);
      end
      for (int i = 0; i < 8; i++) begin
         logic pat;
         pat = ((8'b1011_0010 >> i) & 8'd1) != 8'd0;
         @(posedge clk);
         #1 ext_en = pat;
         @(negedge clk);
         check(sample_en == pat, "R8 follows external enable", int'(sample_en), int'(pat));
      end
      @(posedge clk);
      #1 ext_sel = 1'b0;
      ext_en = 1'b0;

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule